// File: doc/BRIEF.md
# Horizontal Accumulating Video Prescaler

This block narrows a video line by an integer factor before any fine phase scaling. It adds up a programmable run of neighbouring input pixels and turns each run into one output pixel. Each input pixel carries a luma sample and a chroma sample. Both channels use one window counter, so they keep the same window timing and produce their outputs in the same cycle. Two summing modes are available. The first is a flat sum. The second gives the two edge pixels of a window weight one and every inner pixel weight two. The sum is then divided by a programmable power of two and limited to the 8-bit range.

The weighted sum seldom has a DC gain that is an exact power of two, so the shift alone leaves some brightness error. To cover this, the block also computes a fixed-point correction factor for the contrast and saturation stages that follow it. In this factor, 64 means a gain of one. A line starts with a start-of-line flag on its first pixel and ends with an end-of-line flag on its last pixel. A window left incomplete when the line ends is output anyway, and that output carries an end-of-line marker. An accumulation length of zero switches the block to bypass.

Top module: `ps_hprescale`

## Requirements
- R1: While reset is low, and in the first cycle after it, `out_valid` and `corr_valid` are 0.
- R2: With `cfg_wmode`=0 and `cfg_len`=L>0, each window of L+1 accepted pixels gives one output pixel. Its value is min(255, sum >> `cfg_shift`). It is presented with `out_valid`=1 in the cycle after the window's last pixel is accepted.
- R3: With `cfg_wmode`=1 and L>0, window position 0 and position L have weight 1 and every other position has weight 2. The DC gain is then 2·L.
- R4: When a shifted sum exceeds 255, the output is 255.
- R5: When `cfg_len`=0, every accepted pixel comes out unchanged one cycle later. `cfg_shift` and `cfg_wmode` have no effect in this case.
- R6: A pixel accepted with `in_sol`=1 starts a new window at position 0. Any partial sum from before it is discarded without producing an output.
- R7: A pixel accepted with `in_eol`=1 closes the current window even if the window is not full. That output has `out_eol`=1. Positions in the partial window keep the weights they would have in a full window.
- R8: Luma and chroma are summed separately but use the same window boundaries and the same output cycle.
- R9: `corr_value` = floor(64·2^s / G), where G = (m+1)·L + (1−m) for m = `cfg_wmode`. For L=0, G is 1 and s is 0. Otherwise s = `cfg_shift`. `corr_value` is valid when `corr_valid`=1, which is within 20 cycles after the configuration stops changing. It then holds steady while the configuration is unchanged.
- R10: Cycles with `in_valid`=0 neither advance a window nor produce an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| cfg_len | input | 6 | Accumulation length L; the window holds L+1 pixels, and 0 selects bypass |
| cfg_wmode | input | 1 | 0 = flat sum, 1 = edge-weighted 1-2-…-2-1 sum |
| cfg_shift | input | 3 | Normalization right-shift exponent |
| in_valid | input | 1 | Input pixel is present this cycle |
| in_sol | input | 1 | Marks the first pixel of a line |
| in_eol | input | 1 | Marks the last pixel of a line |
| in_luma | input | 8 | Luma sample |
| in_chroma | input | 8 | Chroma sample |
| out_valid | output | 1 | Output pixel is present this cycle |
| out_eol | output | 1 | Output pixel closes the line |
| out_luma | output | 8 | Prescaled luma |
| out_chroma | output | 8 | Prescaled chroma |
| corr_valid | output | 1 | `corr_value` matches the current configuration |
| corr_value | output | 14 | Brightness correction factor, 64 = unity |

## Verification
Whole lines are fed under several settings. A flat-sum line with ramping pixel values shows whether the right pixels are grouped into each window. A weighted line in which luma ramps and chroma is constant checks the edge weights and the independence of the two channels. A line whose pixel count is not a multiple of the window length exercises the flush of the final partial window. Further lines cover saturation, bypass with a large shift configured, an interrupted line followed by a new start-of-line, and a stream broken by idle cycles. The correction factor is checked for several length, mode and shift settings, including the largest gain.

// File: rtl/ps_hprescale_pkg.sv
package ps_hprescale_pkg;

  localparam int PIX_W     = 8;
  localparam int LEN_W     = 6;
  localparam int SHIFT_W   = 3;
  localparam int UNITY_LOG = 6;
  localparam int GAIN_W    = LEN_W + 1;
  localparam int ACC_W     = PIX_W + LEN_W + 1;
  localparam int CORR_W    = UNITY_LOG + (1 << SHIFT_W);

  typedef struct packed {
    logic [LEN_W-1:0]   len;
    logic               wmode;
    logic [SHIFT_W-1:0] shift;
  } cfg_t;

  function automatic logic [GAIN_W-1:0] f_dc_gain(input logic [LEN_W-1:0] len,
                                                  input logic wmode);
    logic [GAIN_W-1:0] g;
    if (len == '0)
      g = GAIN_W'(1);
    else if (wmode)
      g = {len, 1'b0};
    else
      g = GAIN_W'(len) + GAIN_W'(1);
    return g;
  endfunction

  function automatic logic [SHIFT_W-1:0] f_eff_shift(input logic [LEN_W-1:0] len,
                                                     input logic [SHIFT_W-1:0] shift);
    return (len == '0) ? '0 : shift;
  endfunction

endpackage

// File: rtl/ps_window_ctrl.sv
module ps_window_ctrl
  import ps_hprescale_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_wmode,
  input  logic             in_valid,
  input  logic             in_sol,
  input  logic             in_eol,
  output logic             win_first,
  output logic             win_double,
  output logic             win_last,
  output logic             out_valid,
  output logic             out_eol
);

  logic [LEN_W-1:0] pos_q;
  logic [LEN_W-1:0] pos_d;
  logic [LEN_W-1:0] pos_eff;
  logic             at_end;
  logic             pos_en;
  logic             out_valid_d;
  logic             out_eol_d;

  always_comb begin
    pos_eff    = in_sol ? '0 : pos_q;
    win_first  = (pos_eff == '0);
    at_end     = (pos_eff == cfg_len);
    win_double = cfg_wmode && !win_first && !at_end;
    win_last   = at_end || in_eol;
    pos_en     = in_valid;
    pos_d      = win_last ? '0 : pos_eff + LEN_W'(1);
    out_valid_d = in_valid && win_last;
    out_eol_d   = in_valid && in_eol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_eol   <= 1'b0;
    end else begin
      out_valid <= out_valid_d;
      out_eol   <= out_eol_d;
    end
  end

endmodule

// File: rtl/ps_chan_accum.sv
module ps_chan_accum
  import ps_hprescale_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               win_first,
  input  logic               win_double,
  input  logic               win_last,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [PIX_W-1:0]   pix_in,
  output logic [PIX_W-1:0]   pix_out
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] shifted;
  logic [PIX_W-1:0] pix_out_d;
  logic             acc_en;
  logic             out_en;
  logic             overflow;

  always_comb begin
    addend    = win_double ? (ACC_W'(pix_in) << 1) : ACC_W'(pix_in);
    acc_d     = (win_first ? '0 : acc_q) + addend;
    shifted   = acc_d >> shift;
    overflow  = |shifted[ACC_W-1:PIX_W];
    pix_out_d = overflow ? {PIX_W{1'b1}} : shifted[PIX_W-1:0];
    acc_en    = in_valid;
    out_en    = in_valid && win_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out <= '0;
    end else if (out_en) begin
      pix_out <= pix_out_d;
    end
  end

endmodule

// File: rtl/ps_restoring_div.sv
module ps_restoring_div #(
  parameter int NUM_W = 14,
  parameter int DEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             busy,
  output logic [NUM_W-1:0] quot
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] den_q,  den_d;
  logic [DEN_W-1:0] rem_q,  rem_d;
  logic [NUM_W-1:0] quo_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic             busy_d;
  logic [DEN_W:0]   rem_sh;
  logic             fits;

  always_comb begin
    rem_sh = {rem_q, quot[NUM_W-1]};
    fits   = (rem_sh >= {1'b0, den_q});
    den_d  = den_q;
    rem_d  = rem_q;
    quo_d  = quot;
    cnt_d  = cnt_q;
    busy_d = busy;
    if (start) begin
      den_d  = denom;
      rem_d  = '0;
      quo_d  = numer;
      cnt_d  = CNT_W'(NUM_W);
      busy_d = 1'b1;
    end else if (busy) begin
      rem_d  = fits ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
      quo_d  = {quot[NUM_W-2:0], fits};
      cnt_d  = cnt_q - CNT_W'(1);
      busy_d = (cnt_q != CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_q <= '0;
      rem_q <= '0;
      quot  <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      den_q <= den_d;
      rem_q <= rem_d;
      quot  <= quo_d;
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end

endmodule

// File: rtl/ps_gain_corr.sv
module ps_gain_corr
  import ps_hprescale_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  output logic              corr_valid,
  output logic [CORR_W-1:0] corr_value
);

  cfg_t               snap_q;
  logic               primed_q;
  logic               changed;
  logic               div_busy;
  logic [GAIN_W-1:0]  gain;
  logic [SHIFT_W-1:0] eff_shift;
  logic [CORR_W-1:0]  numer;

  always_comb begin
    changed   = !primed_q || (cfg != snap_q);
    gain      = f_dc_gain(cfg.len, cfg.wmode);
    eff_shift = f_eff_shift(cfg.len, cfg.shift);
    numer     = CORR_W'(1 << UNITY_LOG) << eff_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q   <= '0;
      primed_q <= 1'b0;
    end else if (changed) begin
      snap_q   <= cfg;
      primed_q <= 1'b1;
    end
  end

  ps_restoring_div #(
    .NUM_W (CORR_W),
    .DEN_W (GAIN_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (changed),
    .numer (numer),
    .denom (gain),
    .busy  (div_busy),
    .quot  (corr_value)
  );

  assign corr_valid = primed_q && !changed && !div_busy;

endmodule

// File: rtl/ps_hprescale.sv
module ps_hprescale
  import ps_hprescale_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_wmode,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic              in_valid,
  input  logic              in_sol,
  input  logic              in_eol,
  input  logic [PIX_W-1:0]  in_luma,
  input  logic [PIX_W-1:0]  in_chroma,
  output logic              out_valid,
  output logic              out_eol,
  output logic [PIX_W-1:0]  out_luma,
  output logic [PIX_W-1:0]  out_chroma,
  output logic              corr_valid,
  output logic [CORR_W-1:0] corr_value
);

  localparam int NCH = 2;

  logic               win_first;
  logic               win_double;
  logic               win_last;
  logic [SHIFT_W-1:0] eff_shift;
  logic [PIX_W-1:0]   pix_in  [NCH];
  logic [PIX_W-1:0]   pix_out [NCH];
  cfg_t               cfg;

  assign eff_shift = f_eff_shift(cfg_len, cfg_shift);
  assign cfg.len   = cfg_len;
  assign cfg.wmode = cfg_wmode;
  assign cfg.shift = cfg_shift;

  assign pix_in[0]  = in_luma;
  assign pix_in[1]  = in_chroma;
  assign out_luma   = pix_out[0];
  assign out_chroma = pix_out[1];

  ps_window_ctrl u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_len    (cfg_len),
    .cfg_wmode  (cfg_wmode),
    .in_valid   (in_valid),
    .in_sol     (in_sol),
    .in_eol     (in_eol),
    .win_first  (win_first),
    .win_double (win_double),
    .win_last   (win_last),
    .out_valid  (out_valid),
    .out_eol    (out_eol)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    ps_chan_accum u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .win_first  (win_first),
      .win_double (win_double),
      .win_last   (win_last),
      .shift      (eff_shift),
      .pix_in     (pix_in[g]),
      .pix_out    (pix_out[g])
    );
  end

  ps_gain_corr u_corr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .corr_valid (corr_valid),
    .corr_value (corr_value)
  );

endmodule

// File: rtl/ps_hprescale_chk.sv
module ps_hprescale_chk
  import ps_hprescale_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [LEN_W-1:0]   cfg_len,
  input logic               cfg_wmode,
  input logic [SHIFT_W-1:0] cfg_shift,
  input logic               in_valid,
  input logic               in_eol,
  input logic [PIX_W-1:0]   in_luma,
  input logic [PIX_W-1:0]   in_chroma,
  input logic               out_valid,
  input logic               out_eol,
  input logic [PIX_W-1:0]   out_luma,
  input logic [PIX_W-1:0]   out_chroma,
  input logic               corr_valid,
  input logic [CORR_W-1:0]  corr_value
);

  // R2 / R10: an output pixel always follows an accepted input pixel
  p_out_after_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R5: bypass hands each pixel through one cycle later
  p_bypass_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_len == '0) |=>
      (out_valid && out_luma == $past(in_luma) && out_chroma == $past(in_chroma)));

  // R7: end-of-line always yields a flagged output
  p_eol_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eol) |=> (out_valid && out_eol));

  // R7: the end flag never appears without an output
  p_eol_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid);

  // R9: a valid correction holds while the configuration stays put
  p_corr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |=> (!($stable(cfg_len) && $stable(cfg_wmode) && $stable(cfg_shift)) ||
                    (corr_valid && $stable(corr_value))));

endmodule

bind ps_hprescale ps_hprescale_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_len    (cfg_len),
  .cfg_wmode  (cfg_wmode),
  .cfg_shift  (cfg_shift),
  .in_valid   (in_valid),
  .in_eol     (in_eol),
  .in_luma    (in_luma),
  .in_chroma  (in_chroma),
  .out_valid  (out_valid),
  .out_eol    (out_eol),
  .out_luma   (out_luma),
  .out_chroma (out_chroma),
  .corr_valid (corr_valid),
  .corr_value (corr_value)
);

// File: tb/ps_hprescale_tb.sv
module ps_hprescale_tb;

  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic [5:0]  cfg_len;
  logic        cfg_wmode;
  logic [2:0]  cfg_shift;
  logic        in_valid;
  logic        in_sol;
  logic        in_eol;
  logic [7:0]  in_luma;
  logic [7:0]  in_chroma;
  logic        out_valid;
  logic        out_eol;
  logic [7:0]  out_luma;
  logic [7:0]  out_chroma;
  logic        corr_valid;
  logic [13:0] corr_value;

  int n_checks;
  int n_fail;
  bit done;

  int px_l [64];
  int px_c [64];
  int cap_l[64];
  int cap_c[64];
  int cap_e[64];
  int ncap;

  ps_hprescale u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_len    (cfg_len),
    .cfg_wmode  (cfg_wmode),
    .cfg_shift  (cfg_shift),
    .in_valid   (in_valid),
    .in_sol     (in_sol),
    .in_eol     (in_eol),
    .in_luma    (in_luma),
    .in_chroma  (in_chroma),
    .out_valid  (out_valid),
    .out_eol    (out_eol),
    .out_luma   (out_luma),
    .out_chroma (out_chroma),
    .corr_valid (corr_valid),
    .corr_value (corr_value)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && out_valid && ncap < 64) begin
      cap_l[ncap] = out_luma;
      cap_c[ncap] = out_chroma;
      cap_e[ncap] = out_eol;
      ncap = ncap + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int len, input bit wm, input int sh);
    @(negedge clk);
    cfg_len   = 6'(len);
    cfg_wmode = wm;
    cfg_shift = 3'(sh);
    repeat (2) @(negedge clk);
  endtask

  task automatic push(input int l, input int c, input bit sol, input bit eol);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sol    = sol;
    in_eol    = eol;
    in_luma   = 8'(l);
    in_chroma = 8'(c);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sol   = 1'b0;
      in_eol   = 1'b0;
    end
  endtask

  task automatic clear_cap();
    @(posedge clk);
    ncap = 0;
  endtask

  // Feeds px_l/px_c[0..n-1] as one line and compares against the window rule.
  task automatic run_line(input string req, input int n, input int len, input bit wm,
                          input int sh);
    int el[64]; int ec[64]; int ee[64];
    int ne, pos, al, ac, w, s;
    clear_cap();
    for (int i = 0; i < n; i++) push(px_l[i], px_c[i], i == 0, i == n - 1);
    idle(3);
    ne = 0; pos = 0; al = 0; ac = 0;
    s = (len == 0) ? 0 : sh;
    for (int i = 0; i < n; i++) begin
      w = (wm && pos != 0 && pos != len) ? 2 : 1;
      if (pos == 0) begin al = 0; ac = 0; end
      al += w * px_l[i];
      ac += w * px_c[i];
      if (pos == len || i == n - 1) begin
        el[ne] = ((al >> s) > 255) ? 255 : (al >> s);
        ec[ne] = ((ac >> s) > 255) ? 255 : (ac >> s);
        ee[ne] = (i == n - 1);
        ne++;
        pos = 0;
      end else begin
        pos++;
      end
    end
    check(req, "output count", ncap, ne);
    for (int k = 0; k < ne && k < ncap; k++) begin
      check(req, $sformatf("luma[%0d]", k), cap_l[k], el[k]);
      check(req, $sformatf("chroma[%0d]", k), cap_c[k], ec[k]);
      check(req, $sformatf("eol[%0d]", k), cap_e[k], ee[k]);
    end
  endtask

  task automatic t_reset();
    check("R1", "out_valid in reset", out_valid, 0);
    check("R1", "corr_valid in reset", corr_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", out_valid, 0);
    check("R1", "corr_valid first cycle", corr_valid, 0);
  endtask

  task automatic t_plain_r2();
    set_cfg(3, 1'b0, 2);
    for (int i = 0; i < 8; i++) begin px_l[i] = i * 10 + 5; px_c[i] = 200 - i * 7; end
    run_line("R2/R8", 8, 3, 1'b0, 2);
  endtask

  task automatic t_weighted_r3();
    set_cfg(5, 1'b1, 4);
    for (int i = 0; i < 12; i++) begin px_l[i] = 100 + i; px_c[i] = 50; end
    run_line("R3/R8", 12, 5, 1'b1, 4);
  endtask

  task automatic t_saturate_r4();
    set_cfg(3, 1'b0, 0);
    for (int i = 0; i < 4; i++) begin px_l[i] = 100; px_c[i] = 60; end
    run_line("R4", 4, 3, 1'b0, 0);
    check("R4", "saturated luma", cap_l[0], 255);
    check("R4", "unsaturated chroma", cap_c[0], 240);
  endtask

  task automatic t_bypass_r5();
    set_cfg(0, 1'b1, 5);
    for (int i = 0; i < 6; i++) begin px_l[i] = 30 * i + 7; px_c[i] = 250 - 11 * i; end
    run_line("R5", 6, 0, 1'b1, 5);
  endtask

  task automatic t_sol_r6();
    set_cfg(3, 1'b0, 0);
    clear_cap();
    push(90, 90, 1'b1, 1'b0);
    push(90, 90, 1'b0, 1'b0);
    idle(2);
    check("R6", "no output for partial window", ncap, 0);
    push(1, 5, 1'b1, 1'b0);
    push(2, 6, 1'b0, 1'b0);
    push(3, 7, 1'b0, 1'b0);
    push(4, 8, 1'b0, 1'b1);
    idle(3);
    check("R6", "restarted window count", ncap, 1);
    check("R6", "restarted luma", cap_l[0], 10);
    check("R6", "restarted chroma", cap_c[0], 26);
  endtask

  task automatic t_flush_r7();
    set_cfg(4, 1'b0, 0);
    for (int i = 0; i < 7; i++) begin px_l[i] = 20; px_c[i] = 3; end
    run_line("R7", 7, 4, 1'b0, 0);
    check("R7", "flat partial luma", cap_l[1], 40);
    set_cfg(4, 1'b1, 0);
    for (int i = 0; i < 7; i++) begin px_l[i] = 10; px_c[i] = 1; end
    run_line("R7", 7, 4, 1'b1, 0);
    check("R7", "weighted full luma", cap_l[0], 80);
    check("R7", "weighted partial luma", cap_l[1], 30);
  endtask

  task automatic t_gaps_r10();
    set_cfg(2, 1'b0, 0);
    clear_cap();
    push(7, 1, 1'b1, 1'b0);
    idle(3);
    push(8, 2, 1'b0, 1'b0);
    idle(4);
    check("R10", "no output during gaps", ncap, 0);
    push(9, 3, 1'b0, 1'b0);
    idle(3);
    check("R10", "window count", ncap, 1);
    check("R10", "luma sum", cap_l[0], 24);
    check("R10", "chroma sum", cap_c[0], 6);
    check("R10", "no eol flag", cap_e[0], 0);
  endtask

  task automatic corr_case(input int len, input bit wm, input int sh);
    int g, s, exp_v, waited;
    set_cfg(len, wm, sh);
    waited = 0;
    while (!corr_valid && waited < 40) begin @(negedge clk); waited++; end
    check("R9", $sformatf("corr_valid within 20 len=%0d", len), int'(waited <= 20), 1);
    g = (len == 0) ? 1 : (wm ? 2 * len : len + 1);
    s = (len == 0) ? 0 : sh;
    exp_v = (64 << s) / g;
    check("R9", $sformatf("corr len=%0d m=%0d s=%0d", len, wm, sh), corr_value, exp_v);
    repeat (3) @(negedge clk);
    check("R9", "corr held", corr_value, exp_v);
  endtask

  task automatic t_corr_r9();
    corr_case(5, 1'b1, 4);
    corr_case(3, 1'b0, 2);
    corr_case(0, 1'b1, 6);
    corr_case(63, 1'b1, 7);
    corr_case(6, 1'b0, 3);
  endtask

  initial begin
    rst_n = 1'b0; cfg_len = '0; cfg_wmode = 1'b0; cfg_shift = '0;
    in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0; in_luma = '0; in_chroma = '0;
    n_checks = 0; n_fail = 0; ncap = 0; done = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_plain_r2();
    t_weighted_r3();
    t_saturate_r4();
    t_bypass_r5();
    t_sol_r6();
    t_flush_r7();
    t_gaps_r10();
    t_corr_r9();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule